// File: doc/BRIEF.md
# DMA Channel Peripheral Command Handler

This block is the control core of a single DMA channel that a peripheral can steer on its own. Software sets the direction (transmit reads from memory and hands words to the peripheral; receive takes words from the peripheral and writes them to memory), the work-unit length, an interrupt enable and a stop flag. The peripheral can then abort and retry the current work unit with a Restart command, or close it early with a Finish command. The block holds a small word FIFO, a word-offset counter, a count of memory reads still in flight, a descriptor-fetch handshake and a one-cycle completion interrupt.

Both data paths are valid/ready. On the peripheral side `per_req` is valid and `per_gnt` is ready. A word moves on a clock edge where both are high. In transmit mode the word is `per_dout`; in receive mode it is `per_din`. The peripheral may hold `per_req` high for as long as it likes. On the memory side `mem_req` is valid and `mem_ack` is ready. A request may be withdrawn when a command arrives. Read data comes back later, one word per `mem_rvalid` pulse, in issue order. The memory must be able to take every read it has acknowledged. The configuration inputs must stay stable while `cfg_en` is high.

Commands are a one-cycle `cmd_valid` strobe with a two-bit `cmd_code`. Code 01 is Restart and code 10 is Finish; 00 and 11 do nothing. A command is acted on only while the channel is streaming. Every state-changing step is taken on a clock edge, so each output reacts one cycle after its cause.

Top module: `dma_cmd_chan`

## Requirements
- R1: After reset, and while `cfg_en` stays low, `per_gnt`, `mem_req`, `desc_req` and `irq` are all low.
- R2: In transmit mode, reads are issued at offsets 0, 1, 2, … while the offset is below `cfg_len` and FIFO words plus reads in flight are below the FIFO depth. The peripheral receives the words in offset order. `per_gnt` is high only when the FIFO holds data, so it drops once `cfg_len` words have been delivered.
- R3: In receive mode, `per_gnt` is high only when the FIFO has a free entry and the words held plus the words already written are below `cfg_len`. Words are written to offsets 0, 1, 2, … in the order they arrived.
- R4: A transmit Restart drops `per_gnt` in the next cycle. The channel waits for every read in flight, discards the data that comes back, empties the FIFO and sets the offset back to 0. The next word delivered is the word at offset 0.
- R5: A receive Restart discards every FIFO word not yet written, sets the offset back to 0 and grants again two cycles after the command. New words are written from offset 0.
- R6: A transmit Finish drops `per_gnt`. The channel waits for every read in flight, then empties the FIFO and ends the work unit.
- R7: A receive Finish drops `per_gnt`. Every word held in the FIFO is written to memory, and the work unit ends only in the cycle after the last write is acknowledged.
- R8: When a work unit ends, `irq` pulses high for exactly one cycle if `cfg_ien` is 1, and stays low if `cfg_ien` is 0.
- R9: If `cfg_stop` is 0, `desc_req` rises when the work unit ends and stays high until `desc_done`. Streaming then resumes from offset 0.
- R10: If `cfg_stop` is 1, no descriptor is requested after a Finish. `per_gnt` stays low until `cfg_en` has gone low and high again, and streaming then restarts at offset 0.
- R11: A command is ignored unless the channel is streaming. While a Restart or Finish is still being handled, a new command has no effect, and codes 00 and 11 have no effect at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_rx | input | 1 | 1 = receive (memory write), 0 = transmit (memory read) |
| cfg_ien | input | 1 | Work-unit completion interrupt enable |
| cfg_stop | input | 1 | No next descriptor: go idle after Finish |
| cfg_len | input | LW | Work-unit length in words |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 2 | 01 Restart, 10 Finish, others ignored |
| per_req | input | 1 | Peripheral data request (valid) |
| per_gnt | output | 1 | Peripheral data grant (ready) |
| per_din | input | DW | Receive word from the peripheral |
| per_dout | output | DW | Transmit word to the peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | LW | Word offset inside the work unit |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | DW | Read data |
| desc_req | output | 1 | Request to fetch the next descriptor |
| desc_done | input | 1 | Descriptor fetch complete |
| irq | output | 1 | Work-unit completion pulse |

## Verification
If the offset counter is not set back correctly, the first word after a Restart or a descriptor fetch comes from the wrong offset. This shows in the data on the very first transfer. If the in-flight read count is wrong, either a stale word is delivered after a flush or the channel never leaves its drain wait. The bench sees that within a few cycles, as a wrong word or as no `desc_req`. A FIFO that drains early shows at the memory port: the write count at the moment `irq` rises falls short of the number of words accepted. A command that should have been ignored shows as lost writes or as a grant that drops when it should stay high.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // disabled, FIFO held empty
    ST_RUN,    // streaming
    ST_RSTRX,  // receive restart: one-cycle clear
    ST_RSTTX,  // transmit restart: wait for reads in flight
    ST_FINTX,  // transmit finish: wait for reads in flight
    ST_FINRX,  // receive finish: write back FIFO
    ST_DESC,   // waiting for next descriptor
    ST_HALT    // stop mode, waiting for re-enable
  } chan_st_e;

  localparam logic [1:0] CMD_RESTART = 2'b01;
  localparam logic [1:0] CMD_FINISH  = 2'b10;
endpackage

// File: rtl/dcc_fifo.sv
module dcc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_e, pop_e;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign push_e = push && !full && !flush;
  assign pop_e  = pop && !empty && !flush;
  assign dout   = store[rp];

  always_ff @(posedge clk) begin
    if (push_e) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_e) wp <= step(wp);
      if (pop_e)  rp <= step(rp);
      case ({push_e, pop_e})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dcc_pend.sv
module dcc_pend #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dma_cmd_chan.sv
module dma_cmd_chan
  import dma_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_rx,
  input  logic          cfg_ien,
  input  logic          cfg_stop,
  input  logic [LW-1:0] cfg_len,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic          per_req,
  output logic          per_gnt,
  input  logic [DW-1:0] per_din,
  output logic [DW-1:0] per_dout,
  output logic          mem_req,
  output logic          mem_we,
  input  logic          mem_ack,
  output logic [LW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          desc_req,
  input  logic          desc_done,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);

  chan_st_e      st;
  logic [LW-1:0] wcnt;
  logic [CW-1:0] fifo_cnt, pend_cnt;
  logic          fifo_full, fifo_empty;
  logic [DW-1:0] fifo_dout;
  logic          f_push, f_pop, f_flush;
  logic [DW-1:0] f_din;
  logic          rd_ok, wr_ok, mem_hs, per_hs, unit_done, running;

  assign running = (st == ST_RUN);

  // Transmit prefetch window: FIFO words plus reads in flight fill the FIFO at most.
  assign rd_ok = running && !cfg_rx && (wcnt < cfg_len) &&
                 (({1'b0, fifo_cnt} + {1'b0, pend_cnt}) < (CW+1)'(DEPTH));
  assign wr_ok = (running || st == ST_FINRX) && cfg_rx && !fifo_empty;

  assign mem_req   = rd_ok || wr_ok;
  assign mem_we    = cfg_rx;
  assign mem_addr  = wcnt;
  assign mem_wdata = fifo_dout;
  assign mem_hs    = mem_req && mem_ack;

  always_comb begin
    if (cfg_rx)
      per_gnt = running && !fifo_full &&
                (({1'b0, wcnt} + (LW+1)'(fifo_cnt)) < {1'b0, cfg_len});
    else
      per_gnt = running && !fifo_empty;
  end
  assign per_dout = fifo_dout;
  assign per_hs   = per_req && per_gnt;

  assign unit_done = (st == ST_FINTX && pend_cnt == '0) ||
                     (st == ST_FINRX && fifo_empty);
  assign f_flush   = (st == ST_IDLE) || (st == ST_RSTRX) ||
                     ((st == ST_RSTTX || st == ST_FINTX) && pend_cnt == '0);
  // Returned read data is kept only while streaming; otherwise it is dropped.
  assign f_push = cfg_rx ? per_hs : (mem_rvalid && running);
  assign f_din  = cfg_rx ? per_din : mem_rdata;
  assign f_pop  = cfg_rx ? mem_hs : per_hs;

  assign desc_req = (st == ST_DESC);

  dcc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(f_flush), .push(f_push), .din(f_din),
    .pop(f_pop), .dout(fifo_dout), .cnt(fifo_cnt), .full(fifo_full),
    .empty(fifo_empty)
  );

  dcc_pend #(.CW(CW)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(mem_hs && !cfg_rx), .dec(mem_rvalid),
    .cnt(pend_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wcnt <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mem_hs && (running || st == ST_FINRX)) wcnt <= wcnt + 1'b1;
      case (st)
        ST_IDLE: begin
          wcnt <= '0;
          if (cfg_en) st <= ST_RUN;
        end
        ST_RUN: begin
          if (cmd_valid && cmd_code == CMD_RESTART)
            st <= cfg_rx ? ST_RSTRX : ST_RSTTX;
          else if (cmd_valid && cmd_code == CMD_FINISH)
            st <= cfg_rx ? ST_FINRX : ST_FINTX;
        end
        ST_RSTRX: begin
          wcnt <= '0;
          st   <= ST_RUN;
        end
        ST_RSTTX: begin
          if (pend_cnt == '0) begin
            wcnt <= '0;
            st   <= ST_RUN;
          end
        end
        ST_FINTX, ST_FINRX: begin
          if (unit_done) begin
            wcnt <= '0;
            irq  <= cfg_ien;
            st   <= cfg_stop ? ST_HALT : ST_DESC;
          end
        end
        ST_DESC: if (desc_done) st <= ST_RUN;
        ST_HALT: if (!cfg_en) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          cfg_ien,
  input logic          cfg_stop,
  input logic          cfg_rx,
  input logic          per_gnt,
  input logic          desc_req,
  input logic          desc_done,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] pend_cnt
);
  // R2: prefetch never overcommits the FIFO
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_cnt} + {1'b0, pend_cnt}) <= (CW+1)'(DEPTH));
  // R3: receive grant only with room
  a_r3_gnt_room: assert property (@(posedge clk) disable iff (!rst_n)
    (per_gnt && cfg_rx) |-> (fifo_cnt < CW'(DEPTH)));
  // R6 and R7: unit closes only with nothing buffered and nothing in flight
  a_r7_irq_drained: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fifo_cnt == '0 && pend_cnt == '0));
  // R8: interrupt gated and one cycle wide
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_ien);
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9: descriptor request held until done
  a_r9_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_done) |=> desc_req);
  // R10: stop mode never requests a descriptor and never grants
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_stop) |=> (!desc_req && !per_gnt));
endmodule

bind dma_cmd_chan dcc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_ien(cfg_ien), .cfg_stop(cfg_stop),
  .cfg_rx(cfg_rx), .per_gnt(per_gnt), .desc_req(desc_req),
  .desc_done(desc_done), .fifo_cnt(fifo_cnt), .pend_cnt(pend_cnt)
);

// File: tb/tb_dma_cmd_chan.sv
module tb_dma_cmd_chan;
  localparam int DW = 8, DEPTH = 4, LW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_rx = 0, cfg_ien = 0, cfg_stop = 0;
  logic [LW-1:0] cfg_len = 8;
  logic cmd_valid = 0;
  logic [1:0] cmd_code = 0;
  logic per_req = 0, per_gnt;
  logic [DW-1:0] per_din = 0, per_dout;
  logic mem_req, mem_we, mem_ack;
  logic [LW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_rvalid;
  logic desc_req, desc_done = 0;
  logic irq;

  logic ack_en = 1;
  int   lat = 2;
  logic       sh_v [4];
  logic [7:0] sh_d [4];
  logic [7:0] wmem [16];
  int   irq_cnt = 0, wr_cnt = 0, wr_at_irq = -1;
  int   n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign mem_ack    = mem_req && ack_en;
  assign mem_rvalid = sh_v[0];
  assign mem_rdata  = sh_d[0];

  dma_cmd_chan #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rx(cfg_rx),
    .cfg_ien(cfg_ien), .cfg_stop(cfg_stop), .cfg_len(cfg_len),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .per_req(per_req),
    .per_gnt(per_gnt), .per_din(per_din), .per_dout(per_dout),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .desc_req(desc_req), .desc_done(desc_done),
    .irq(irq)
  );

  function automatic logic [7:0] f(int a);
    return 8'(a * 13 + 5);
  endfunction

  // memory model: fixed read latency, immediate writes
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin sh_v[i] <= 0; sh_d[i] <= 0; end
      for (int i = 0; i < 16; i++) wmem[i] <= 0;
      irq_cnt <= 0; wr_cnt <= 0; wr_at_irq <= -1;
    end else begin
      for (int i = 0; i < 3; i++) begin sh_v[i] <= sh_v[i+1]; sh_d[i] <= sh_d[i+1]; end
      sh_v[3] <= 0;
      if (mem_req && mem_ack && !mem_we) begin
        sh_v[lat-1] <= 1; sh_d[lat-1] <= f(int'(mem_addr));
      end
      if (mem_req && mem_ack && mem_we) begin
        wmem[mem_addr[3:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1;
      end
      if (irq) begin irq_cnt <= irq_cnt + 1; wr_at_irq <= wr_cnt; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_en = 0; per_req = 0; cmd_valid = 0; desc_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic start(input bit rx, input int len, input bit ien, input bit stp);
    do_reset();
    cfg_rx = rx; cfg_len = LW'(len); cfg_ien = ien; cfg_stop = stp;
    cfg_en = 1;
    @(negedge clk);
  endtask

  task automatic take(output logic [7:0] d);
    per_req = 1;
    for (int i = 0; i < 40 && !per_gnt; i++) @(negedge clk);
    d = per_gnt ? per_dout : 8'hXX;
    @(negedge clk);
    per_req = 0;
  endtask

  task automatic give(input logic [7:0] v);
    per_din = v; per_req = 1;
    for (int i = 0; i < 40 && !per_gnt; i++) @(negedge clk);
    @(negedge clk);
    per_req = 0;
  endtask

  task automatic cmd(input logic [1:0] c);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0; cmd_code = 0;
  endtask

  task automatic wait_desc(output bit seen);
    for (int i = 0; i < 40 && !desc_req; i++) @(negedge clk);
    seen = desc_req;
  endtask

  task automatic done_desc();
    desc_done = 1;
    @(negedge clk);
    desc_done = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    logic [7:0] d;
    bit seen, bad_g, bad_d;
    int i0;

    // R1: reset and disabled state
    do_reset();
    repeat (3) @(negedge clk);
    chk(!per_gnt && !mem_req && !desc_req && !irq, "R1",
        {per_gnt, mem_req, desc_req, irq}, 0);

    // R2: transmit streaming, latency sweep
    for (int l = 1; l <= 3; l++) begin
      lat = l; ack_en = 1;
      start(0, 8, 0, 0);
      for (int i = 0; i < 8; i++) begin
        take(d); chk(d == f(i), "R2 data", d, f(i));
      end
      repeat (4) @(negedge clk);
      chk(!per_gnt, "R2 len cap", per_gnt, 0);
    end

    // R4: transmit restart
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      start(0, 8, 0, 0);
      for (int i = 0; i < 3; i++) take(d);
      cmd(2'b01);
      chk(!per_gnt, "R4 grant drop", per_gnt, 0);
      take(d); chk(d == f(0), "R4 first", d, f(0));
      take(d); chk(d == f(1), "R4 second", d, f(1));
    end

    // R6 R8 R9: transmit finish, interrupt enable swept
    for (int l = 1; l <= 3; l++) begin
      for (int e = 0; e < 2; e++) begin
        lat = l;
        start(0, 8, e[0], 0);
        take(d); take(d);
        cmd(2'b10);
        chk(!per_gnt, "R6 grant drop", per_gnt, 0);
        wait_desc(seen);
        chk(seen, "R9 desc_req", seen, 1);
        done_desc();
        chk(irq_cnt == e, "R8 irq count", irq_cnt, e);
        take(d); chk(d == f(0), "R9 restart offset", d, f(0));
      end
    end

    // R10: stop mode
    lat = 2;
    start(0, 8, 1, 1);
    take(d);
    cmd(2'b10);
    bad_g = 0; bad_d = 0;
    repeat (20) begin
      @(negedge clk);
      if (per_gnt) bad_g = 1;
      if (desc_req) bad_d = 1;
    end
    chk(!bad_g, "R10 grant low", bad_g, 0);
    chk(!bad_d, "R10 no desc", bad_d, 0);
    chk(irq_cnt == 1, "R8 stop irq", irq_cnt, 1);
    cfg_en = 0; repeat (2) @(negedge clk);
    cfg_en = 1; @(negedge clk);
    take(d); chk(d == f(0), "R10 re-enable", d, f(0));

    // R3: receive path
    ack_en = 1;
    start(1, 8, 0, 0);
    for (int i = 0; i < 6; i++) give(8'(8'hA0 + i));
    repeat (3) @(negedge clk);
    chk(wr_cnt == 6, "R3 count", wr_cnt, 6);
    for (int i = 0; i < 6; i++)
      chk(wmem[i] == 8'(8'hA0 + i), "R3 data", wmem[i], 8'hA0 + i);

    ack_en = 0;
    start(1, 2, 0, 0);
    give(8'h11); give(8'h12);
    chk(!per_gnt, "R3 len cap", per_gnt, 0);
    start(1, 8, 0, 0);
    for (int i = 0; i < 4; i++) give(8'h20);
    chk(!per_gnt, "R3 full", per_gnt, 0);

    // R5: receive restart
    ack_en = 0;
    start(1, 8, 0, 0);
    give(8'hA0); give(8'hA1); give(8'hA2);
    cmd(2'b01);
    chk(wr_cnt == 0, "R5 no write", wr_cnt, 0);
    ack_en = 1;
    give(8'hB0); give(8'hB1);
    repeat (3) @(negedge clk);
    chk(wr_cnt == 2, "R5 count", wr_cnt, 2);
    chk(wmem[0] == 8'hB0, "R5 word0", wmem[0], 8'hB0);
    chk(wmem[1] == 8'hB1, "R5 word1", wmem[1], 8'hB1);

    // R7 R11: receive finish with ignored commands during drain
    ack_en = 0;
    start(1, 8, 1, 0);
    for (int i = 0; i < 4; i++) give(8'(8'hC0 + i));
    cmd(2'b10);
    chk(!per_gnt, "R7 grant drop", per_gnt, 0);
    cmd(2'b01);
    cmd(2'b11);
    ack_en = 1;
    wait_desc(seen);
    done_desc();
    chk(wr_at_irq == 4, "R7 writes before irq", wr_at_irq, 4);
    chk(irq_cnt == 1, "R8 rx irq", irq_cnt, 1);
    for (int i = 0; i < 4; i++)
      chk(wmem[i] == 8'(8'hC0 + i), "R11 busy restart ignored", wmem[i], 8'hC0 + i);

    // R11: codes 00 and 11 ignored while streaming
    ack_en = 0;
    start(1, 8, 1, 0);
    give(8'h51); give(8'h52);
    cmd(2'b11);
    cmd(2'b00);
    ack_en = 1;
    i0 = irq_cnt;
    repeat (5) @(negedge clk);
    chk(wr_cnt == 2, "R11 writes kept", wr_cnt, 2);
    chk(irq_cnt == i0, "R11 no irq", irq_cnt, i0);
    chk(per_gnt, "R11 still granting", per_gnt, 1);

    summary();
  end
endmodule